// File: doc/BRIEF.md
# ALU Status Flag Unit

This block holds the status byte of an 8-bit accumulator-based controller. Each cycle it may take an arithmetic or logic outcome from the datapath and turn it into carry, digit-carry and zero flags. Subtraction is formed as `A + ~B + 1`, so both carry flags mean "no borrow" when a subtraction sets them. The block computes carry and digit carry from the operands. It takes the zero flag from the result word that the datapath supplies.

The same register holds two power-management flags. Each is driven by a one-cycle event strobe: watchdog clear, sleep and watchdog overflow. A synchronous active-low reset stands for power-up. Software may write the three arithmetic flags through a simple write port. The two power flags and the three spare bits cannot be written. The flags are registered, so `status` shows an update one clock edge after the inputs that cause it.

Top module: `status_flags`

## Requirements
- R1: With `rst_n` low at a clock edge, `status` becomes 8'h18: power-down (bit 3) and time-out (bit 4) are 1, and all other bits are 0.
- R2: With `op_cls` = 2'b01 (add), carry (bit 0) takes the carry out of bit 7 of `opnd_a + opnd_b`, and digit carry (bit 1) takes the carry out of bit 3 of the low-nibble sum.
- R3: With `op_cls` = 2'b10 (subtract `opnd_a - opnd_b`), carry is 1 exactly when `opnd_a >= opnd_b` unsigned. Digit carry is 1 exactly when `opnd_a[3:0] >= opnd_b[3:0]`.
- R4: For any `op_cls` other than 2'b00, zero (bit 2) becomes 1 exactly when `alu_result` is 0.
- R5: With `op_cls` = 2'b11 (logic), carry and digit carry keep their values. With `op_cls` = 2'b00, carry, digit carry and zero all keep their values.
- R6: With `wr_en` high and `op_cls` = 2'b00, bits 2..0 of `status` load `wr_data[2:0]`. When `op_cls` is not 2'b00, a write has no effect.
- R7: Writes to bits 7..3 are ignored. Bits 7..5 always read 0.
- R8: A `clrwdt_stb` pulse sets power-down and time-out to 1.
- R9: A `sleep_stb` pulse clears power-down and sets time-out. When it arrives together with `clrwdt_stb`, power-down is still cleared.
- R10: A `wdt_to_stb` pulse clears time-out and leaves power-down unchanged. It takes priority over `clrwdt_stb` and `sleep_stb` for the time-out bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| op_cls | input | 2 | Operation class: 00 none, 01 add, 10 subtract, 11 logic |
| opnd_a | input | 8 | First operand (minuend for subtract) |
| opnd_b | input | 8 | Second operand (subtrahend for subtract) |
| alu_result | input | 8 | Datapath result, used for the zero flag |
| wr_en | input | 1 | Software write strobe for the status byte |
| wr_data | input | 8 | Software write data |
| clrwdt_stb | input | 1 | Watchdog-clear instruction event |
| sleep_stb | input | 1 | Sleep instruction event |
| wdt_to_stb | input | 1 | Watchdog overflow event |
| status | output | 8 | Status byte |

## Verification
Every flag is a visible register bit, so wrong internal state appears on `status` one edge after its cause. The bench compares each field after every clock. A corrupted carry or digit carry that a logic op or an idle cycle should preserve stays visible over the following cycles, and the next arithmetic op exposes it again. A wrong power flag stays wrong until a later strobe rewrites it, so event orderings are checked directly after the pulse. The bench uses random operands, with directed checks at the 8-bit and nibble wrap points and at equal operands for subtraction.

// File: rtl/stat_pkg.sv
// Package: shared operation classes and status bit positions.
// Assumes an 8-bit status byte; the bit positions are architectural.
package stat_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_ADD   = 2'b01,
        OP_SUB   = 2'b10,
        OP_LOGIC = 2'b11
    } alu_cls_e;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned BIT_C  = 0;
    localparam int unsigned BIT_DC = 1;
    localparam int unsigned BIT_Z  = 2;
    localparam int unsigned BIT_PD = 3;
    localparam int unsigned BIT_TO = 4;
    localparam int unsigned USED_W = BIT_TO + 1;
endpackage

// File: rtl/arith_flags.sv
// Module: carry and digit-carry generation for add and subtract.
// Subtract is formed as a + ~b + 1, so the carries mean "no borrow".
// Assumes NIB_W < DATA_W. The block is purely combinational.
module arith_flags #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    output logic              carry,
    output logic              dcarry
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    low_sum;

    // Select the true or inverted second operand and add the carry-in.
    always_comb begin
        b_eff    = is_sub ? ~b : b;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
        low_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, is_sub};
        carry    = full_sum[DATA_W];
        dcarry   = low_sum[NIB_W];
    end
endmodule

// File: rtl/zero_detect.sv
// Module: reduces a result word to a single "all zero" flag.
// Assumes nothing beyond the width parameter. The block is combinational.
module zero_detect #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] res,
    output logic              is_zero
);
    // NOR reduction of the result word.
    always_comb is_zero = ~|res;
endmodule

// File: rtl/pwr_flags.sv
// Module: power-down and time-out flag pair.
// Assumes single-cycle event strobes. Reset is power-up and sets both flags.
// Priorities: sleep beats clear for power-down; overflow beats both for time-out.
module pwr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clrwdt_stb,
    input  logic sleep_stb,
    input  logic wdt_to_stb,
    output logic pd_q,
    output logic to_q
);
    // Power-down flag: set by clear, cleared by sleep (sleep wins).
    always_ff @(posedge clk) begin
        if (!rst_n)          pd_q <= 1'b1;
        else if (sleep_stb)  pd_q <= 1'b0;
        else if (clrwdt_stb) pd_q <= 1'b1;
    end

    // Time-out flag: cleared by overflow, set by clear or sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                        to_q <= 1'b1;
        else if (wdt_to_stb)               to_q <= 1'b0;
        else if (clrwdt_stb || sleep_stb)  to_q <= 1'b1;
    end

    AST_SLEEP_CLEARS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_stb |=> !pd_q); // R9
    AST_CLEAR_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (clrwdt_stb && !sleep_stb && !wdt_to_stb) |=> (pd_q && to_q)); // R8
    AST_OVERFLOW_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to_stb |=> !to_q); // R10
    AST_OVERFLOW_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to_stb && !sleep_stb && !clrwdt_stb) |=> $stable(pd_q)); // R10
endmodule

// File: rtl/status_flags.sv
// Module: status register for the ALU (top).
// Carry and digit carry come from the operands; zero comes from the supplied result.
// Assumes alu_result matches the operation for arithmetic classes.
// A software write touches bits 2..0 only, and only on cycles with no operation.
module status_flags
    import stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_cls,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              clrwdt_stb,
    input  logic              sleep_stb,
    input  logic              wdt_to_stb,
    output logic [STAT_W-1:0] status
);
    localparam int unsigned SPARE_W = STAT_W - USED_W;

    alu_cls_e cls;
    logic     arith_c, arith_dc, res_zero;
    logic     c_q, dc_q, z_q, pd_q, to_q;
    logic     is_arith;

    // Decode the operation class.
    always_comb begin
        cls      = alu_cls_e'(op_cls);
        is_arith = (cls == OP_ADD) || (cls == OP_SUB);
    end

    arith_flags #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .is_sub (cls == OP_SUB),
        .carry  (arith_c),
        .dcarry (arith_dc)
    );

    zero_detect #(.DATA_W(DATA_W)) u_zero (
        .res     (alu_result),
        .is_zero (res_zero)
    );

    pwr_flags u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clrwdt_stb (clrwdt_stb),
        .sleep_stb  (sleep_stb),
        .wdt_to_stb (wdt_to_stb),
        .pd_q       (pd_q),
        .to_q       (to_q)
    );

    // Carry and digit carry: arithmetic updates, idle-cycle write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q  <= 1'b0;
            dc_q <= 1'b0;
        end else if (is_arith) begin
            c_q  <= arith_c;
            dc_q <= arith_dc;
        end else if (cls == OP_NONE && wr_en) begin
            c_q  <= wr_data[BIT_C];
            dc_q <= wr_data[BIT_DC];
        end
    end

    // Zero flag: any operation updates it, idle-cycle write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                     z_q <= 1'b0;
        else if (cls != OP_NONE)        z_q <= res_zero;
        else if (wr_en)                 z_q <= wr_data[BIT_Z];
    end

    // Assemble the status byte; spare bits are tied low.
    generate
        if (SPARE_W > 0) begin : g_spare
            assign status[STAT_W-1:USED_W] = '0;
        end
    endgenerate
    assign status[BIT_C]  = c_q;
    assign status[BIT_DC] = dc_q;
    assign status[BIT_Z]  = z_q;
    assign status[BIT_PD] = pd_q;
    assign status[BIT_TO] = to_q;

    AST_ZERO_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls != 2'b00) |=> (status[BIT_Z] == ($past(alu_result) == '0))); // R4
    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 2'b11) |=> (status[1:0] == $past(status[1:0]))); // R5
    AST_WRITE_SKIPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clrwdt_stb && !sleep_stb && !wdt_to_stb) |=> $stable(status[4:3])); // R7
    AST_WRITE_BLOCKED_BY_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_cls == 2'b11) |=> (status[1:0] == $past(status[1:0]))); // R6
endmodule

// File: tb/status_flags_tb.sv
module status_flags_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_cls = 2'b00;
    logic [7:0] opnd_a = '0, opnd_b = '0, alu_result = '0, wr_data = '0;
    logic       wr_en = 1'b0, clrwdt_stb = 1'b0, sleep_stb = 1'b0, wdt_to_stb = 1'b0;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [7:0] exp_st;

    status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .alu_result(alu_result), .wr_en(wr_en),
        .wr_data(wr_data), .clrwdt_stb(clrwdt_stb), .sleep_stb(sleep_stb),
        .wdt_to_stb(wdt_to_stb), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog on the bench itself.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYCLES) begin
            n_bad++;
            $display("FAIL watchdog (all R): run hung, actual cycles=%0d expected<=%0d", cyc, MAX_CYCLES);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of the next status byte from the requirements.
    function automatic logic [7:0] ref_next(input logic [7:0] s);
        logic [7:0] n;
        n = s;
        n[7:5] = 3'b000;
        case (op_cls)
            2'b01: begin
                n[0] = (int'(opnd_a) + int'(opnd_b)) > 255;
                n[1] = (int'(opnd_a[3:0]) + int'(opnd_b[3:0])) > 15;
                n[2] = (alu_result == 8'h00);
            end
            2'b10: begin
                n[0] = opnd_a >= opnd_b;
                n[1] = opnd_a[3:0] >= opnd_b[3:0];
                n[2] = (alu_result == 8'h00);
            end
            2'b11: n[2] = (alu_result == 8'h00);
            default: if (wr_en) n[2:0] = wr_data[2:0];
        endcase
        if (sleep_stb) n[3] = 1'b0;
        else if (clrwdt_stb) n[3] = 1'b1;
        if (wdt_to_stb) n[4] = 1'b0;
        else if (clrwdt_stb || sleep_stb) n[4] = 1'b1;
        return n;
    endfunction

    // Apply the current inputs for one edge, then compare every field.
    task automatic step;
        logic [7:0] e;
        string cr;
        e = ref_next(exp_st);
        cr = (op_cls == 2'b01) ? "R2" : (op_cls == 2'b10) ? "R3" :
             (op_cls == 2'b11) ? "R5" : (wr_en ? "R6" : "R5");
        @(posedge clk);
        #1;
        exp_st = e;
        chk({cr, " carry"},  {7'd0, status[0]}, {7'd0, e[0]});
        chk({cr, " dcarry"}, {7'd0, status[1]}, {7'd0, e[1]});
        chk((op_cls != 2'b00) ? "R4 zero" : "R6 zero", {7'd0, status[2]}, {7'd0, e[2]});
        chk(sleep_stb ? "R9 pd" : (clrwdt_stb ? "R8 pd" : (wdt_to_stb ? "R10 pd" : "R7 pd")),
            {7'd0, status[3]}, {7'd0, e[3]});
        chk(wdt_to_stb ? "R10 to" : (clrwdt_stb ? "R8 to" : (sleep_stb ? "R9 to" : "R7 to")),
            {7'd0, status[4]}, {7'd0, e[4]});
        chk("R7 spare", {5'd0, status[7:5]}, 8'h00);
        @(negedge clk);
        op_cls = 2'b00; wr_en = 1'b0; clrwdt_stb = 1'b0; sleep_stb = 1'b0; wdt_to_stb = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] c, input logic [7:0] a, input logic [7:0] b);
        op_cls = c; opnd_a = a; opnd_b = b;
        alu_result = (c == 2'b01) ? a + b : (c == 2'b10) ? a - b : (a & b);
        step();
    endtask

    initial begin
        void'($urandom(32'd1357));
        exp_st = 8'h18;
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R1 reset", status, 8'h18);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        do_op(2'b01, 8'hFF, 8'h01);            // R2 wrap: C=1 DC=1 Z=1
        chk("R2 wrap", status, 8'h1F);
        do_op(2'b01, 8'h0F, 8'h01);            // R2 nibble only
        chk("R2 nibble", status, 8'h1A);
        do_op(2'b10, 8'h42, 8'h42);            // R3 equal: no borrow, zero
        chk("R3 equal", status, 8'h1F);
        do_op(2'b10, 8'h10, 8'h01);            // R3 nibble borrow only
        chk("R3 nibble borrow", status, 8'h19);
        do_op(2'b10, 8'h00, 8'h01);            // R3 full borrow
        chk("R3 borrow", status, 8'h18);
        do_op(2'b01, 8'h88, 8'h88);            // set C, DC
        do_op(2'b11, 8'hF0, 8'h0F);            // R5 logic keeps C/DC, Z=1
        chk("R5 logic hold", status, 8'h1F);
        wr_en = 1'b1; wr_data = 8'hE0; step(); // R6/R7 write clears 2..0, ignores 7..3
        chk("R7 write ignore", status, 8'h18);
        wr_en = 1'b1; wr_data = 8'h05; op_cls = 2'b11; opnd_a = 8'h01; opnd_b = 8'h01;
        alu_result = 8'h01; step();            // R6 write blocked by op
        chk("R6 blocked", status, 8'h18);
        sleep_stb = 1'b1; step();
        chk("R9 sleep", status, 8'h10);
        wdt_to_stb = 1'b1; step();
        chk("R10 overflow", status, 8'h00);
        clrwdt_stb = 1'b1; step();
        chk("R8 clear", status, 8'h18);
        clrwdt_stb = 1'b1; sleep_stb = 1'b1; step();
        chk("R9 both", status, 8'h10);
        clrwdt_stb = 1'b1; wdt_to_stb = 1'b1; step();
        chk("R10 priority", status, 8'h08);

        // Constrained random traffic
        for (int i = 0; i < 2000; i++) begin
            int sel;
            sel = $urandom_range(0, 3);
            op_cls = sel[1:0];
            opnd_a = 8'($urandom);
            opnd_b = ($urandom_range(0, 7) == 0) ? opnd_a : 8'($urandom);
            case (op_cls)
                2'b01:   alu_result = opnd_a + opnd_b;
                2'b10:   alu_result = opnd_a - opnd_b;
                2'b11:   alu_result = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
                default: alu_result = 8'($urandom);
            endcase
            wr_en      = ($urandom_range(0, 3) == 0);
            wr_data    = 8'($urandom);
            clrwdt_stb = ($urandom_range(0, 7) == 0);
            sleep_stb  = ($urandom_range(0, 7) == 0);
            wdt_to_stb = ($urandom_range(0, 9) == 0);
            step();
        end

        // R1 again: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #1 chk("R1 reset again", status, 8'h18);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule